// File: doc/BRIEF.md
# SECDED Codec with Check-Bit Fault Injection

This block protects a 64-bit data word with an 8-bit check code that corrects any single flipped bit and detects any double flip. The write side takes a data word and returns it together with its check code one clock later. The read side takes a stored data word and its stored check code. One clock later it returns the corrected data, the raw syndrome, and a correctable or uncorrectable flag.

A small control word lets test software corrupt the stored code on purpose. It holds an 8-bit XOR pattern, a one-shot arm bit and a writeback-enable bit. While armed, the next write has its check code XORed with the pattern, and the arm bit then clears itself. When writeback is enabled, each corrected read also raises a one-cycle request so that the corrected word can be stored back.

Top module: `ecc_codec_top`

## Requirements
- R1: The check code of a write is the bitwise XOR of the parity columns of all set data bits. The columns for data bits 0..63 are, in order, f4 f1 ec ea e9 e6 e5 e3 dc da d9 d6 d5 d3 ce cb b5 b0 ad ab a8 a7 a4 a2 9d 9b 98 97 94 92 8f 8a 75 70 6d 6b 68 67 64 62 5e 5b 58 57 54 52 4f 4a 34 31 2c 2a 29 26 25 23 1c 1a 19 16 15 13 0e 0b (hex). `enc_valid`, `enc_data` and `enc_check` appear one clock after `wr_valid`.
- R2: A read whose data and check code agree gives a zero syndrome and unchanged data, and raises neither flag.
- R3: A read with exactly one flipped data bit j returns the original data. It raises `dec_ce` but not `dec_ue`, and its syndrome equals column j.
- R4: A read with exactly one flipped check bit k returns the data unchanged. It raises `dec_ce`, and its syndrome equals the one-hot value 1<<k.
- R5: Any nonzero syndrome that matches no column raises `dec_ue` and not `dec_ce`. Every even-weight nonzero syndrome falls in this class, so every double flip is reported as uncorrectable.
- R6: The control word is loaded whole by `ctl_wr` and read back on `ctl_rdata`. The XOR pattern is in bits 23:16, the arm bit in bit 8 and writeback enable in bit 24. All other bits read as zero.
- R7: While the arm bit is set, the next write has its check code XORed with the pattern, and the arm bit reads zero after that write. Writes made while disarmed use the clean code. If `ctl_wr` and `wr_valid` occur in the same cycle, the write uses the old control word and the new word is loaded.
- R8: An armed write with pattern 0x03, when read back, is reported as uncorrectable.
- R9: `wb_req` pulses, in the same cycle as `dec_valid`, exactly when a read is correctable and writeback is enabled.
- R10: After reset, `enc_valid`, `dec_valid`, `dec_ce`, `dec_ue` and `wb_req` are low and the control word is zero.
- R11: `dec_valid` follows `rd_valid` by one clock, and the flags and `wb_req` are low in every cycle where `dec_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Load the control word |
| ctl_wdata | input | 32 | Control word value |
| ctl_rdata | output | 32 | Current control word |
| wr_valid | input | 1 | Write word present |
| wr_data | input | 64 | Data to encode |
| enc_valid | output | 1 | Encoded word valid |
| enc_data | output | 64 | Data to store |
| enc_check | output | 8 | Check code to store (possibly corrupted) |
| rd_valid | input | 1 | Stored word present |
| rd_data | input | 64 | Stored data |
| rd_check | input | 8 | Stored check code |
| dec_valid | output | 1 | Decode result valid |
| dec_data | output | 64 | Corrected data |
| dec_syndrome | output | 8 | Raw syndrome |
| dec_ce | output | 1 | Single error corrected |
| dec_ue | output | 1 | Uncorrectable error |
| wb_req | output | 1 | Writeback request for the corrected word |

## Verification
The encode results, the decode results and the writeback request all come one clock after the input that caused them. A control-word load shows on `ctl_rdata` one clock after `ctl_wr`, and an armed write clears the arm bit in that same clock. The bench drives each input on a falling edge and reads the results at the following falling edge, half a cycle after the rising edge that registered them. In this way each check looks at exactly the cycle its result belongs to. Randomly chosen words with no flip, with one data flip, with one check flip or with two flips are checked against a codec model written inside the bench.

// File: rtl/ecc_codec_pkg.sv
// Shared constants of the SECDED codec: word widths and the fixed parity
// columns of the 64 data bits. Check bit k always uses column 1<<k.
package ecc_codec_pkg;
    localparam int DATA_W = 64;
    localparam int CHK_W  = 8;

    // Parity column of each data bit, index = data bit position.
    localparam logic [7:0] DATA_COL [0:63] = '{
        8'hf4, 8'hf1, 8'hec, 8'hea, 8'he9, 8'he6, 8'he5, 8'he3,
        8'hdc, 8'hda, 8'hd9, 8'hd6, 8'hd5, 8'hd3, 8'hce, 8'hcb,
        8'hb5, 8'hb0, 8'had, 8'hab, 8'ha8, 8'ha7, 8'ha4, 8'ha2,
        8'h9d, 8'h9b, 8'h98, 8'h97, 8'h94, 8'h92, 8'h8f, 8'h8a,
        8'h75, 8'h70, 8'h6d, 8'h6b, 8'h68, 8'h67, 8'h64, 8'h62,
        8'h5e, 8'h5b, 8'h58, 8'h57, 8'h54, 8'h52, 8'h4f, 8'h4a,
        8'h34, 8'h31, 8'h2c, 8'h2a, 8'h29, 8'h26, 8'h25, 8'h23,
        8'h1c, 8'h1a, 8'h19, 8'h16, 8'h15, 8'h13, 8'h0e, 8'h0b
    };

    // Bit positions inside the control word.
    localparam int CTL_ARM_BIT  = 8;
    localparam int CTL_PAT_LO   = 16;
    localparam int CTL_WBEN_BIT = 24;
endpackage

// File: rtl/ecc_encoder.sv
// Combinational check-code generator. It assumes DATA_W <= 64, since the
// column table covers 64 data bits.
module ecc_encoder
    import ecc_codec_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CHK_W
) (
    input  logic [DW-1:0] data_i,
    output logic [CW-1:0] check_o
);
    // XOR the column of every set data bit.
    always_comb begin
        check_o = '0;
        for (int i = 0; i < DW; i++) begin
            if (data_i[i]) check_o = check_o ^ DATA_COL[i][CW-1:0];
        end
    end
endmodule

// File: rtl/ecc_decoder.sv
// Combinational syndrome decoder. It flips the single data bit whose column
// matches the syndrome. A one-hot syndrome marks a check-bit error, and every
// other nonzero syndrome is uncorrectable. It assumes that all columns are
// distinct and nonzero.
module ecc_decoder
    import ecc_codec_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CHK_W
) (
    input  logic [DW-1:0] data_i,
    input  logic [CW-1:0] check_i,
    output logic [DW-1:0] data_o,
    output logic [CW-1:0] syndrome_o,
    output logic          ce_o,
    output logic          ue_o
);
    logic [CW-1:0] recomputed;
    logic [DW-1:0] hit;
    logic          chk_hit;
    logic          any_err;

    ecc_encoder #(.DW(DW), .CW(CW)) u_recalc (
        .data_i  (data_i),
        .check_o (recomputed)
    );

    assign syndrome_o = recomputed ^ check_i;

    // One comparator per data bit against its column.
    for (genvar j = 0; j < DW; j++) begin : g_match
        assign hit[j] = (syndrome_o == DATA_COL[j][CW-1:0]);
    end

    // Classify the syndrome and repair the data word.
    always_comb begin
        chk_hit = $onehot(syndrome_o);
        any_err = |syndrome_o;
        data_o  = data_i ^ hit;
        ce_o    = (|hit) | chk_hit;
        ue_o    = any_err & ~ce_o;
    end
endmodule

// File: rtl/ecc_inject_ctl.sv
// Control word for fault injection: XOR pattern, one-shot arm bit and
// writeback enable. A load wins over the self-clear caused by a write in the
// same cycle, and that write still sees the old value.
module ecc_inject_ctl
    import ecc_codec_pkg::*;
#(
    parameter int CW = CHK_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_wr,
    input  logic [31:0]   ctl_wdata,
    input  logic          wr_valid,
    output logic [CW-1:0] inj_mask_o,
    output logic          wb_en_o,
    output logic [31:0]   ctl_rdata
);
    logic [CW-1:0] pat_q;
    logic          arm_q;
    logic          wben_q;
    logic          unused_bits;

    // Load the fields, or disarm after a write has used the pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pat_q  <= '0;
            arm_q  <= 1'b0;
            wben_q <= 1'b0;
        end else if (ctl_wr) begin
            pat_q  <= ctl_wdata[CTL_PAT_LO +: CW];
            arm_q  <= ctl_wdata[CTL_ARM_BIT];
            wben_q <= ctl_wdata[CTL_WBEN_BIT];
        end else if (wr_valid && arm_q) begin
            arm_q  <= 1'b0;
        end
    end

    // Readback image, with every unassigned bit at zero.
    always_comb begin
        ctl_rdata                       = '0;
        ctl_rdata[CTL_PAT_LO +: CW]     = pat_q;
        ctl_rdata[CTL_ARM_BIT]          = arm_q;
        ctl_rdata[CTL_WBEN_BIT]         = wben_q;
    end

    assign inj_mask_o  = arm_q ? pat_q : '0;
    assign wb_en_o     = wben_q;
    assign unused_bits = ^{ctl_wdata[31:25], ctl_wdata[15:9], ctl_wdata[7:0]};
endmodule

// File: rtl/ecc_codec_top.sv
// SECDED codec top. The write path registers the data and its (possibly
// injected) check code. The read path registers the corrected data, the
// syndrome, the flags and the writeback request. Both paths have a latency
// of one clock.
module ecc_codec_top
    import ecc_codec_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CHK_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_wr,
    input  logic [31:0]   ctl_wdata,
    output logic [31:0]   ctl_rdata,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    output logic          enc_valid,
    output logic [DW-1:0] enc_data,
    output logic [CW-1:0] enc_check,
    input  logic          rd_valid,
    input  logic [DW-1:0] rd_data,
    input  logic [CW-1:0] rd_check,
    output logic          dec_valid,
    output logic [DW-1:0] dec_data,
    output logic [CW-1:0] dec_syndrome,
    output logic          dec_ce,
    output logic          dec_ue,
    output logic          wb_req
);
    logic [CW-1:0] wr_check_c;
    logic [CW-1:0] inj_mask;
    logic          wb_en;
    logic [DW-1:0] fix_data_c;
    logic [CW-1:0] syn_c;
    logic          ce_c;
    logic          ue_c;

    ecc_inject_ctl #(.CW(CW)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr     (ctl_wr),
        .ctl_wdata  (ctl_wdata),
        .wr_valid   (wr_valid),
        .inj_mask_o (inj_mask),
        .wb_en_o    (wb_en),
        .ctl_rdata  (ctl_rdata)
    );

    ecc_encoder #(.DW(DW), .CW(CW)) u_enc (
        .data_i  (wr_data),
        .check_o (wr_check_c)
    );

    ecc_decoder #(.DW(DW), .CW(CW)) u_dec (
        .data_i     (rd_data),
        .check_i    (rd_check),
        .data_o     (fix_data_c),
        .syndrome_o (syn_c),
        .ce_o       (ce_c),
        .ue_o       (ue_c)
    );

    // Write-path register: capture the word and its injected code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enc_valid <= 1'b0;
            enc_data  <= '0;
            enc_check <= '0;
        end else begin
            enc_valid <= wr_valid;
            if (wr_valid) begin
                enc_data  <= wr_data;
                enc_check <= wr_check_c ^ inj_mask;
            end
        end
    end

    // Read-path register: the result and flags, qualified by rd_valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid    <= 1'b0;
            dec_data     <= '0;
            dec_syndrome <= '0;
            dec_ce       <= 1'b0;
            dec_ue       <= 1'b0;
            wb_req       <= 1'b0;
        end else begin
            dec_valid    <= rd_valid;
            dec_data     <= fix_data_c;
            dec_syndrome <= syn_c;
            dec_ce       <= rd_valid & ce_c;
            dec_ue       <= rd_valid & ue_c;
            wb_req       <= rd_valid & ce_c & wb_en;
        end
    end
endmodule

// File: rtl/ecc_codec_sva.sv
// Checker for ecc_codec_top, bound to every instance of it.
module ecc_codec_sva #(
    parameter int DW = 64,
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ctl_wr,
    input logic [31:0]   ctl_rdata,
    input logic          wr_valid,
    input logic          enc_valid,
    input logic          rd_valid,
    input logic          dec_valid,
    input logic [DW-1:0] dec_data,
    input logic [CW-1:0] dec_syndrome,
    input logic          dec_ce,
    input logic          dec_ue,
    input logic          wb_req
);
    a_r1_enc_latency: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> enc_valid);

    a_r2_zero_syn_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_syndrome == '0) |-> (!dec_ce && !dec_ue));

    a_r5_even_weight_ue: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_syndrome != '0 && !$countones(dec_syndrome)[0]) |-> dec_ue);

    a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_ce && dec_ue));

    a_r7_arm_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && ctl_rdata[8] && !ctl_wr) |=> !ctl_rdata[8]);

    a_r9_wb_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> (dec_ce && ctl_rdata[24]));

    a_r11_dec_latency: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> dec_valid);

    a_r11_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> (!dec_ce && !dec_ue && !wb_req));

    logic unused_data;
    assign unused_data = ^dec_data;
endmodule

bind ecc_codec_top ecc_codec_sva #(.DW(DW), .CW(CW)) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl_wr       (ctl_wr),
    .ctl_rdata    (ctl_rdata),
    .wr_valid     (wr_valid),
    .enc_valid    (enc_valid),
    .rd_valid     (rd_valid),
    .dec_valid    (dec_valid),
    .dec_data     (dec_data),
    .dec_syndrome (dec_syndrome),
    .dec_ce       (dec_ce),
    .dec_ue       (dec_ue),
    .wb_req       (wb_req)
);

// File: tb/ecc_codec_top_tb.sv
module ecc_codec_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic [31:0] ctl_rdata;
    logic        wr_valid = 1'b0;
    logic [63:0] wr_data = '0;
    logic        enc_valid;
    logic [63:0] enc_data;
    logic [7:0]  enc_check;
    logic        rd_valid = 1'b0;
    logic [63:0] rd_data = '0;
    logic [7:0]  rd_check = '0;
    logic        dec_valid;
    logic [63:0] dec_data;
    logic [7:0]  dec_syndrome;
    logic        dec_ce, dec_ue, wb_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ecc_codec_top u_dut (.*);

    localparam logic [7:0] TB_COL [0:63] = '{
        8'hf4, 8'hf1, 8'hec, 8'hea, 8'he9, 8'he6, 8'he5, 8'he3,
        8'hdc, 8'hda, 8'hd9, 8'hd6, 8'hd5, 8'hd3, 8'hce, 8'hcb,
        8'hb5, 8'hb0, 8'had, 8'hab, 8'ha8, 8'ha7, 8'ha4, 8'ha2,
        8'h9d, 8'h9b, 8'h98, 8'h97, 8'h94, 8'h92, 8'h8f, 8'h8a,
        8'h75, 8'h70, 8'h6d, 8'h6b, 8'h68, 8'h67, 8'h64, 8'h62,
        8'h5e, 8'h5b, 8'h58, 8'h57, 8'h54, 8'h52, 8'h4f, 8'h4a,
        8'h34, 8'h31, 8'h2c, 8'h2a, 8'h29, 8'h26, 8'h25, 8'h23,
        8'h1c, 8'h1a, 8'h19, 8'h16, 8'h15, 8'h13, 8'h0e, 8'h0b
    };

    function automatic logic [7:0] ref_code(input logic [63:0] d);
        logic [7:0] c = '0;
        for (int i = 0; i < 64; i++) if (d[i]) c ^= TB_COL[i];
        return c;
    endfunction

    task automatic expect_eq(input string req, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load_ctl(input logic [31:0] w);
        @(negedge clk); ctl_wr = 1'b1; ctl_wdata = w;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic do_write(input logic [63:0] d, output logic [63:0] od, output logic [7:0] oc);
        @(negedge clk); wr_valid = 1'b1; wr_data = d;
        @(negedge clk); wr_valid = 1'b0;
        expect_eq("R1 enc_valid", 80'(enc_valid), 80'd1);
        od = enc_data; oc = enc_check;
    endtask

    task automatic do_read(input logic [63:0] d, input logic [7:0] c);
        @(negedge clk); rd_valid = 1'b1; rd_data = d; rd_check = c;
        @(negedge clk); rd_valid = 1'b0;
        expect_eq("R11 dec_valid", 80'(dec_valid), 80'd1);
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        logic [63:0] d, od, fd;
        logic [7:0]  oc, fc;
        void'($urandom(32'd20240517));

        repeat (3) @(negedge clk);
        expect_eq("R10 enc_valid reset", 80'(enc_valid), 80'd0);
        expect_eq("R10 dec flags reset", 80'({dec_valid, dec_ce, dec_ue, wb_req}), 80'd0);
        expect_eq("R10 ctl reset", 80'(ctl_rdata), 80'd0);
        @(negedge clk); rst_n = 1'b1;

        // R1 directed: single bits give their own column.
        do_write(64'h1, od, oc);
        expect_eq("R1 bit0 column", 80'(oc), 80'hf4);
        do_write(64'h8000_0000_0000_0000, od, oc);
        expect_eq("R1 bit63 column", 80'({od, oc}), {64'h8000_0000_0000_0000, 8'h0b});
        do_write(64'h0, od, oc);
        expect_eq("R1 zero word", 80'(oc), 80'h00);

        // R6 field layout and readback.
        load_ctl(32'hFFFF_FFFF);
        expect_eq("R6 readback all ones", 80'(ctl_rdata), 80'h01FF_0100);
        load_ctl(32'h0);
        expect_eq("R6 readback zero", 80'(ctl_rdata), 80'h0);

        // Random mix of none / single data / single check / double flips.
        for (int n = 0; n < 200; n++) begin
            int kind, a, b;
            d = {$urandom, $urandom};
            do_write(d, od, oc);
            expect_eq("R1 random code", 80'({od, oc}), {d, ref_code(d)});
            kind = $urandom_range(3, 0);
            fd = od; fc = oc;
            a = $urandom_range(71, 0);
            b = (a + 1 + $urandom_range(70, 0)) % 72;
            if (kind == 1) begin
                a = a % 64; fd[a] = ~fd[a];
                do_read(fd, fc);
                expect_eq("R3 data flip", 80'({dec_data, dec_syndrome, dec_ce, dec_ue}),
                          80'({d, TB_COL[a], 2'b10}));
            end else if (kind == 2) begin
                a = a % 8; fc[a] = ~fc[a];
                do_read(fd, fc);
                expect_eq("R4 check flip", 80'({dec_data, dec_syndrome, dec_ce, dec_ue}),
                          80'({d, 8'(1 << a), 2'b10}));
            end else if (kind == 3) begin
                if (a < 64) fd[a] = ~fd[a]; else fc[a-64] = ~fc[a-64];
                if (b < 64) fd[b] = ~fd[b]; else fc[b-64] = ~fc[b-64];
                do_read(fd, fc);
                expect_eq("R5 double flip", 80'({dec_ce, dec_ue}), 80'b01);
            end else begin
                do_read(fd, fc);
                expect_eq("R2 clean read", 80'({dec_data, dec_syndrome, dec_ce, dec_ue}),
                          80'({d, 8'h00, 2'b00}));
            end
            expect_eq("R9 no wb when disabled", 80'(wb_req), 80'd0);
        end

        // R5 directed: even-weight syndrome 0x03 matches no column.
        do_read(64'h0, 8'h03);
        expect_eq("R5 syndrome 03", 80'({dec_syndrome, dec_ce, dec_ue}), 80'({8'h03, 2'b01}));

        // R7 and R8: armed write with pattern 0x03.
        d = 64'h0123_4567_89AB_CDEF;
        load_ctl(32'h0003_0100);
        expect_eq("R6 armed readback", 80'(ctl_rdata), 80'h0003_0100);
        do_write(d, od, oc);
        expect_eq("R7 masked code", 80'(oc), 80'(ref_code(d) ^ 8'h03));
        expect_eq("R7 arm self-clears", 80'(ctl_rdata), 80'h0003_0000);
        do_read(od, oc);
        expect_eq("R8 pattern 03 uncorrectable", 80'({dec_ce, dec_ue}), 80'b01);
        do_write(d, od, oc);
        expect_eq("R7 next write clean", 80'(oc), 80'(ref_code(d)));

        // R7: single-bit pattern gives a correctable read.
        load_ctl(32'h0180_0100);
        do_write(d, od, oc);
        expect_eq("R7 pattern 80", 80'(oc), 80'(ref_code(d) ^ 8'h80));
        do_read(od, oc);
        expect_eq("R4 injected check flip", 80'({dec_data, dec_syndrome, dec_ce, dec_ue}),
                  80'({d, 8'h80, 2'b10}));
        expect_eq("R9 wb on ce", 80'(wb_req), 80'd1);
        do_read(d, ref_code(d));
        expect_eq("R9 no wb on clean", 80'(wb_req), 80'd0);
        do_read(d, ref_code(d) ^ 8'h11);
        expect_eq("R9 no wb on ue", 80'({wb_req, dec_ue}), 80'b01);

        // R7: a load in the same cycle as a write; the write uses the old word.
        load_ctl(32'h0005_0100);
        @(negedge clk); wr_valid = 1'b1; wr_data = d; ctl_wr = 1'b1; ctl_wdata = 32'h0009_0100;
        @(negedge clk); wr_valid = 1'b0; ctl_wr = 1'b0;
        expect_eq("R7 collision old pattern", 80'(enc_check), 80'(ref_code(d) ^ 8'h05));
        expect_eq("R7 collision load wins", 80'(ctl_rdata), 80'h0009_0100);

        // R11: idle cycle shows no valid and no flags.
        @(negedge clk);
        expect_eq("R11 idle", 80'({dec_valid, dec_ce, dec_ue, wb_req}), 80'd0);

        done = 1;
        report();
    end
endmodule